// File: doc/BRIEF.md
# Destination Address Acceptance Filter

This block sits behind a receive MAC's address parser and decides, for each incoming frame, whether its 48-bit destination address should be kept. The parser presents the address together with a one-cycle valid strobe. The block registers an accept or reject verdict one clock later, along with the 6-bit hash index it computed.

The decision combines several rules. A copy-everything mode accepts any frame. Broadcast handling can be switched off. An exact comparison is made against a programmed station address. A 64-entry hash table, supplied as two 32-bit words, is looked up for multicast destinations and, if enabled, for unicast destinations as well. The hash is a plain XOR fold of the address into six bits, not a CRC. The address, station and table inputs are static configuration held by the surrounding logic.

Top module: `mac_dest_filter`

## Requirements
- R1: While reset is asserted and after it is released with no strobe, `resValid` and `accept` are 0.
- R2: `resValid` is 1 in exactly the cycle after each cycle with `addrValid` = 1, and 0 otherwise.
- R3: Address bit p is `destAddr[p]`, which is bit (p mod 8) of byte (p div 8), with byte 0 the first byte on the wire. Bit k of `hashIdx` is the XOR of all bits p with p mod 6 = k. `hashIdx` is valid with `resValid`.
- R4: A destination is multicast when `destAddr[0]` = 1. A non-broadcast multicast is accepted when `cfgMcastHash` = 1 and the table bit at its index is 1. Indices 0-31 are bits of `tblLow`, and indices 32-63 are bits 0-31 of `tblHigh`.
- R5: A multicast with `cfgMcastHash` = 0, or whose table bit is 0, is rejected unless another rule accepts it.
- R6: With both table words all ones and `cfgMcastHash` = 1, every multicast destination is accepted.
- R7: With `cfgCopyAll` = 1, every destination is accepted.
- R8: The all-ones destination is accepted when `cfgNoBcast` = 0. It is rejected when `cfgNoBcast` = 1 even if its table bit is set, unless `cfgCopyAll` = 1.
- R9: A destination equal to the station address is accepted. The match requires `destAddr[31:0]` = `stationLow` and `destAddr[47:32]` = `stationHigh`.
- R10: A station address of all zeros never matches, so an all-zero destination is rejected when no other rule applies.
- R11: With `cfgUcastHash` = 1, a unicast destination whose table bit is 1 is accepted. With `cfgUcastHash` = 0, the same destination is rejected.
- R12: `accept` is 0 in every cycle in which `resValid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addrValid | input | 1 | Destination address strobe |
| destAddr | input | 48 | Destination address, byte 0 in bits 7:0 |
| stationLow | input | 32 | Station address bytes 0-3 |
| stationHigh | input | 16 | Station address bytes 4-5 |
| tblLow | input | 32 | Hash table entries 0-31 |
| tblHigh | input | 32 | Hash table entries 32-63 |
| cfgCopyAll | input | 1 | Accept every frame |
| cfgMcastHash | input | 1 | Enable hash lookup for multicast |
| cfgUcastHash | input | 1 | Enable hash lookup for unicast |
| cfgNoBcast | input | 1 | Reject the broadcast address |
| resValid | output | 1 | Verdict valid |
| accept | output | 1 | Frame accepted |
| hashIdx | output | 6 | Hash index of the presented address |

## Verification
The bench compares `hashIdx` against an independent byte-and-bit walk of the fold for a range of addresses. A design that numbered bits MSB-first within a byte, or folded modulo 8, would report wrong indices.

The boundary indices 31 and 32 are hit deliberately. Swapping the table words, or being off by one at the seam, would accept the wrong frames.

Broadcast is tested with its table bit set and with broadcast disabled. A filter that let the hash override the broadcast rule would accept that frame.

An all-zero station is tested against an all-zero destination, which an unguarded comparator would accept. Unicast hashing is toggled to catch a lookup that ignores the multicast bit.

// File: rtl/mdf_pkg.sv
package mdf_pkg;
  parameter int ADDR_W = 48;
  parameter int IDX_W  = 6;
  parameter int WORD_W = 32;
  localparam int TBL_W = 1 << IDX_W;

  typedef struct packed {
    logic capture;
  } strobes_t;

  typedef struct packed {
    logic isBcast;
    logic isMcast;
    logic stationHit;
    logic tableHit;
  } flags_t;
endpackage

// File: rtl/mdf_hash_fold.sv
module mdf_hash_fold #(
  parameter int ADDR_W = 48,
  parameter int IDX_W  = 6
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx
);
  generate
    for (genvar k = 0; k < IDX_W; k++) begin : g_fold
      always_comb begin
        idx[k] = 1'b0;
        for (int p = k; p < ADDR_W; p += IDX_W) begin
          idx[k] = idx[k] ^ addr[p];
        end
      end
    end
  endgenerate
endmodule

// File: rtl/mdf_datapath.sv
module mdf_datapath
  import mdf_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int IW = IDX_W,
  parameter int WW = WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobes_t          stb,
  input  logic [AW-1:0]     destAddr,
  input  logic [WW-1:0]     stationLow,
  input  logic [AW-WW-1:0]  stationHigh,
  input  logic [WW-1:0]     tblLow,
  input  logic [WW-1:0]     tblHigh,
  output flags_t            flags,
  output logic [IW-1:0]     hashIdx
);
  logic [IW-1:0]     foldIdx;
  logic [2*WW-1:0]   table64;
  logic [AW-1:0]     station;
  logic              stationOn;

  mdf_hash_fold #(.ADDR_W(AW), .IDX_W(IW)) fold_i (
    .addr (destAddr),
    .idx  (foldIdx)
  );

  assign table64   = {tblHigh, tblLow};
  assign station   = {stationHigh, stationLow};
  assign stationOn = |station;

  always_comb begin
    flags.isBcast    = &destAddr;
    flags.isMcast    = destAddr[0];
    flags.stationHit = stationOn && (destAddr == station);
    flags.tableHit   = table64[foldIdx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hashIdx <= '0;
    else if (stb.capture) hashIdx <= foldIdx;
  end
endmodule

// File: rtl/mdf_control.sv
module mdf_control
  import mdf_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     addrValid,
  input  logic     cfgCopyAll,
  input  logic     cfgMcastHash,
  input  logic     cfgUcastHash,
  input  logic     cfgNoBcast,
  input  flags_t   flags,
  output strobes_t stb,
  output logic     resValid,
  output logic     accept
);
  logic verdict;

  assign stb.capture = addrValid;

  always_comb begin
    if (cfgCopyAll)            verdict = 1'b1;
    else if (flags.isBcast)    verdict = !cfgNoBcast;
    else if (flags.stationHit) verdict = 1'b1;
    else if (flags.isMcast)    verdict = cfgMcastHash && flags.tableHit;
    else                       verdict = cfgUcastHash && flags.tableHit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resValid <= 1'b0;
      accept   <= 1'b0;
    end else begin
      resValid <= addrValid;
      accept   <= addrValid && verdict;
    end
  end
endmodule

// File: rtl/mac_dest_filter.sv
module mac_dest_filter
  import mdf_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    addrValid,
  input  logic [ADDR_W-1:0]       destAddr,
  input  logic [WORD_W-1:0]       stationLow,
  input  logic [ADDR_W-WORD_W-1:0] stationHigh,
  input  logic [WORD_W-1:0]       tblLow,
  input  logic [WORD_W-1:0]       tblHigh,
  input  logic                    cfgCopyAll,
  input  logic                    cfgMcastHash,
  input  logic                    cfgUcastHash,
  input  logic                    cfgNoBcast,
  output logic                    resValid,
  output logic                    accept,
  output logic [IDX_W-1:0]        hashIdx
);
  strobes_t stb;
  flags_t   flags;

  mdf_datapath dp_i (
    .clk (clk), .rst_n (rst_n), .stb (stb), .destAddr (destAddr),
    .stationLow (stationLow), .stationHigh (stationHigh),
    .tblLow (tblLow), .tblHigh (tblHigh), .flags (flags), .hashIdx (hashIdx)
  );

  mdf_control ctl_i (
    .clk (clk), .rst_n (rst_n), .addrValid (addrValid),
    .cfgCopyAll (cfgCopyAll), .cfgMcastHash (cfgMcastHash),
    .cfgUcastHash (cfgUcastHash), .cfgNoBcast (cfgNoBcast),
    .flags (flags), .stb (stb), .resValid (resValid), .accept (accept)
  );
endmodule

// File: rtl/mac_dest_filter_chk.sv
module mac_dest_filter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        addrValid,
  input logic [47:0] destAddr,
  input logic        cfgCopyAll,
  input logic        cfgNoBcast,
  input logic        resValid,
  input logic        accept
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    addrValid |=> resValid); // R2
  AST_VALID_CAUSED: assert property (@(posedge clk) disable iff (!rst_n)
    resValid |-> $past(addrValid)); // R2
  AST_QUIET_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !resValid |-> !accept); // R12
  AST_COPY_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (addrValid && cfgCopyAll) |=> accept); // R7
  AST_BCAST_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (addrValid && (&destAddr) && cfgNoBcast && !cfgCopyAll) |=> !accept); // R8
endmodule

bind mac_dest_filter mac_dest_filter_chk chk_i (
  .clk (clk), .rst_n (rst_n), .addrValid (addrValid), .destAddr (destAddr),
  .cfgCopyAll (cfgCopyAll), .cfgNoBcast (cfgNoBcast),
  .resValid (resValid), .accept (accept)
);

// File: tb/mac_dest_filter_tb.sv
module mac_dest_filter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        addrValid = 1'b0;
  logic [47:0] destAddr = '0;
  logic [31:0] stationLow = '0;
  logic [15:0] stationHigh = '0;
  logic [31:0] tblLow = '0;
  logic [31:0] tblHigh = '0;
  logic        cfgCopyAll = 1'b0, cfgMcastHash = 1'b0, cfgUcastHash = 1'b0, cfgNoBcast = 1'b0;
  logic        resValid, accept;
  logic [5:0]  hashIdx;
  int          nRun = 0, nFail = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  mac_dest_filter dut_i (.*);

  function automatic logic [5:0] refIdx(input logic [47:0] a);
    logic [5:0] r = '0;
    for (int b = 0; b < 6; b++) begin
      logic [7:0] byteV = a[8*b +: 8];
      for (int j = 0; j < 8; j++) begin
        int pos = 8*b + j;
        if (byteV[j]) r[pos % 6] = ~r[pos % 6];
      end
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one strobe at a falling edge, sample verdict one falling edge later
  task automatic present(input logic [47:0] a, output logic v, output logic acc, output logic [5:0] ix);
    @(negedge clk);
    destAddr = a; addrValid = 1'b1;
    @(negedge clk);
    addrValid = 1'b0;
    v = resValid; acc = accept; ix = hashIdx;
  endtask

  task automatic tReset();
    chk("R1 valid in reset", resValid, 0);
    chk("R1 accept in reset", accept, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R1 valid after reset", resValid, 0);
    chk("R1 accept after reset", accept, 0);
  endtask

  task automatic tLatency();
    logic v, a; logic [5:0] ix;
    present(48'h1, v, a, ix);
    chk("R2 valid one cycle later", v, 1);
    @(negedge clk);
    chk("R2 valid drops", resValid, 0);
    chk("R12 accept low when not valid", accept, 0);
  endtask

  task automatic tFold();
    logic v, a; logic [5:0] ix;
    logic [47:0] pats [8] = '{48'h0, 48'h1, 48'h3F, 48'hFFFF_FFFF_FFFF,
      48'h0123_4567_89AB, 48'h8000_0000_0000, 48'h0100_5E00_00FB, 48'hA5C3_1E77_0F02};
    foreach (pats[n]) begin
      present(pats[n], v, a, ix);
      chk("R3 hash index", ix, refIdx(pats[n]));
    end
  endtask

  task automatic tMcastHash();
    logic v, a; logic [5:0] ix;
    cfgMcastHash = 1; tblLow = 32'h2; tblHigh = 0;   // index 1
    present(48'h1, v, a, ix);  chk("R4 mcast table hit", a, 1);
    tblLow = 0; tblHigh = 32'h8000_0000;              // index 63 in high word
    present(48'h3F, v, a, ix); chk("R4 mcast high word bit", a, 1);
    tblLow = 32'h8000_0000; tblHigh = 32'h1;          // index 31 and 32
    present(48'h1F, v, a, ix); chk("R4 index 31", {26'd0, ix}, 31); chk("R4 index 31 accepted", a, 1);
    tblLow = 32'h8000_0000; tblHigh = 0;
    present(48'h21, v, a, ix); chk("R4 index 33 rejected", a, 0);
    tblLow = 0; tblHigh = 32'h1;
    present(48'h21, v, a, ix); chk("R5 index 33 bit clear", a, 0);
    present(48'h61, v, a, ix); chk("R4 index 32 accepted", a, 1);
    tblLow = 32'h2; tblHigh = 0; cfgMcastHash = 0;
    present(48'h1, v, a, ix);  chk("R5 mcast hash disabled", a, 0);
    cfgMcastHash = 1;
    present(48'h3, v, a, ix);  chk("R5 mcast bit clear", a, 0);
    tblLow = '1; tblHigh = '1;
    present(48'h0123_4567_89AB, v, a, ix); chk("R6 all ones table", a, 1);
    present(48'hFEDC_BA98_7653, v, a, ix); chk("R6 all ones table 2", a, 1);
    tblLow = 0; tblHigh = 0; cfgMcastHash = 0;
  endtask

  task automatic tCopyAll();
    logic v, a; logic [5:0] ix;
    cfgCopyAll = 1; cfgNoBcast = 1;
    present(48'h1234_5678_9ABC, v, a, ix); chk("R7 copy all unicast", a, 1);
    present(48'hFFFF_FFFF_FFFF, v, a, ix); chk("R7 copy all bcast", a, 1);
    cfgCopyAll = 0; cfgNoBcast = 0;
  endtask

  task automatic tBcast();
    logic v, a; logic [5:0] ix;
    present(48'hFFFF_FFFF_FFFF, v, a, ix); chk("R8 bcast accepted", a, 1);
    cfgNoBcast = 1; cfgMcastHash = 1; tblLow = 32'h1;  // broadcast folds to index 0
    present(48'hFFFF_FFFF_FFFF, v, a, ix); chk("R8 bcast blocked despite table", a, 0);
    cfgNoBcast = 0; cfgMcastHash = 0; tblLow = 0;
  endtask

  task automatic tStation();
    logic v, a; logic [5:0] ix;
    stationLow = 32'h6655_4400; stationHigh = 16'h2211;
    present(48'h2211_6655_4400, v, a, ix); chk("R9 exact match", a, 1);
    present(48'h2210_6655_4400, v, a, ix); chk("R9 high mismatch", a, 0);
    present(48'h2211_6655_4402, v, a, ix); chk("R9 low mismatch", a, 0);
    stationLow = 0; stationHigh = 0;
    present(48'h0, v, a, ix); chk("R10 zero station never matches", a, 0);
  endtask

  task automatic tUcastHash();
    logic v, a; logic [5:0] ix;
    logic [47:0] u = 48'h0000_0000_0002;              // unicast, index 2
    tblLow = 32'h4;
    present(u, v, a, ix); chk("R11 ucast hash off", a, 0);
    cfgUcastHash = 1;
    present(u, v, a, ix); chk("R11 ucast hash on", a, 1);
    tblLow = 0;
    present(u, v, a, ix); chk("R11 ucast bit clear", a, 0);
    cfgUcastHash = 0;
  endtask

  initial begin
    #10;
    tReset();
    tLatency();
    tFold();
    tMcastHash();
    tCopyAll();
    tBcast();
    tStation();
    tUcastHash();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nRun++; nFail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule